// File: doc/BRIEF.md
# Switching-Band Circulating Current Detector

This block watches a bank of parallel inverter modules that share DC and AC buses. On each sample strobe it receives the three phase currents of every module as signed fixed-point values. For each module it forms the zero-sequence current, which is the phase sum divided by three and truncated toward zero. It then subtracts the zero-sequence value held from the previous strobe. Samples arrive at twice the PWM carrier rate, for example 6 kHz for a 3 kHz carrier. At that rate the difference between consecutive samples is the carrier-band ripple. Its sign flips from one sample to the next, so the block keeps only its absolute value as the module's switching-band magnitude.

The block also finds the worst module. The largest magnitude across all modules becomes the reference magnitude, and the number of the module that produced it is reported with it. When a disturbance changes which module ripples most, the reference moves to that module on the next strobe. A phase-compensation controller downstream uses the reference magnitude and index to decide which carrier to treat as the anchor.

Top module: `circ_ripple_detect`

## Requirements
- R1: The zero-sequence value of a module is (ia + ib + ic) / 3, truncated toward zero. For example, a phase sum of -5 gives -1, and a sum of 8 gives 2.
- R2: On every strobe after the first, each module's magnitude on `mag_out` is |zs_now - zs_prev|. Module m occupies bits [m*W_IN +: W_IN].
- R3: Results are registered. `out_valid` is high for exactly the one cycle that follows a strobe cycle, and all outputs hold their values in cycles with no strobe.
- R4: The first strobe after reset only records the zero-sequence values. It raises no `out_valid` and leaves every output at zero.
- R5: While reset is asserted, and until the first result, all outputs read zero and `out_valid` is low.
- R6: `ref_mag` equals the largest of the module magnitudes.
- R7: `ref_idx` is the module whose magnitude equals `ref_mag`. When magnitudes tie, the lowest module number is reported.
- R8: The reference follows the largest module from strobe to strobe, so it changes as soon as another module becomes largest.
- R9: A full-scale swing, from all phases at the most positive code to all phases at the most negative code, gives a magnitude of 2^W_IN - 1 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | One-cycle pulse marking a new set of current samples |
| cur_in | input | N_MOD*3*W_IN | Signed phase currents; module m, phase p at bits [(m*3+p)*W_IN +: W_IN] |
| mag_out | output | N_MOD*W_IN | Unsigned switching-band magnitude of each module |
| ref_mag | output | W_IN | Largest module magnitude |
| ref_idx | output | IDX_W | Number of the module holding the reference |
| out_valid | output | 1 | High in the cycle after a strobe that produced results |

## Verification
On every strobe the block picks the reference and resolves ties in the same cycle. The tests provoke this by giving two modules the same largest magnitude in a single sample. The expected result is the lower module number, with a reference magnitude equal to that shared value. The rounding toward zero of negative sums is also exercised on the same strobe that updates the reference. The bench computes the expected value with its own integer division.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
package ccd_pkg;
    localparam int NUM_PHASES = 3;

    function automatic int idx_width(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction
endpackage

// File: rtl/zseq_div3.sv
`timescale 1ns/1ps
// Zero-sequence current of one module: phase sum / 3, truncated toward zero.
module zseq_div3 #(
    parameter int W_IN = 16
) (
    input  logic signed [W_IN-1:0] ph_a,
    input  logic signed [W_IN-1:0] ph_b,
    input  logic signed [W_IN-1:0] ph_c,
    output logic signed [W_IN-1:0] zs
);
    localparam int W_SUM  = W_IN + 2;
    localparam int SHIFT  = W_SUM + 1;
    localparam int W_PROD = W_SUM + SHIFT;
    localparam logic [SHIFT-1:0] RECIP = SHIFT'(((64'd1 << SHIFT) + 64'd2) / 64'd3);

    logic signed [W_SUM-1:0] sum;
    logic                    neg;
    logic        [W_SUM-1:0] mag_sum;
    logic       [W_PROD-1:0] prod;
    logic         [W_IN-1:0] quot;

    always_comb begin
        sum     = W_SUM'(ph_a) + W_SUM'(ph_b) + W_SUM'(ph_c);
        neg     = sum[W_SUM-1];
        mag_sum = neg ? W_SUM'(-sum) : W_SUM'(sum);
        prod    = W_PROD'(mag_sum) * W_PROD'(RECIP);
        quot    = W_IN'(prod >> SHIFT);
        zs      = neg ? -$signed(quot) : $signed(quot);
    end
endmodule

// File: rtl/ripple_abs.sv
`timescale 1ns/1ps
// Magnitude of the change between two zero-sequence samples.
module ripple_abs #(
    parameter int W_IN = 16
) (
    input  logic signed [W_IN-1:0] zs_now,
    input  logic signed [W_IN-1:0] zs_prev,
    output logic        [W_IN-1:0] mag
);
    logic signed [W_IN:0] diff;

    always_comb begin
        diff = (W_IN+1)'(zs_now) - (W_IN+1)'(zs_prev);
        mag  = diff[W_IN] ? W_IN'(-diff) : W_IN'(diff);
    end
endmodule

// File: rtl/peak_pick.sv
`timescale 1ns/1ps
// Largest magnitude and its module number; the lower number wins ties.
module peak_pick #(
    parameter int N_MOD = 4,
    parameter int W_IN  = 16,
    parameter int IDX_W = 2
) (
    input  logic [N_MOD-1:0][W_IN-1:0] mags,
    output logic            [W_IN-1:0] peak,
    output logic           [IDX_W-1:0] peak_idx
);
    always_comb begin
        peak     = mags[0];
        peak_idx = '0;
        for (int m = 1; m < N_MOD; m++) begin
            if (mags[m] > peak) begin
                peak     = mags[m];
                peak_idx = IDX_W'(m);
            end
        end
    end
endmodule

// File: rtl/circ_ripple_detect.sv
`timescale 1ns/1ps
module circ_ripple_detect
    import ccd_pkg::*;
#(
    parameter int N_MOD = 4,
    parameter int W_IN  = 16,
    parameter int IDX_W = idx_width(N_MOD)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_stb,
    input  logic [N_MOD*NUM_PHASES*W_IN-1:0] cur_in,
    output logic [N_MOD*W_IN-1:0]         mag_out,
    output logic [W_IN-1:0]               ref_mag,
    output logic [IDX_W-1:0]              ref_idx,
    output logic                          out_valid
);
    typedef struct packed {
        logic [N_MOD-1:0][W_IN-1:0] prev;
        logic                       primed;
        logic [N_MOD-1:0][W_IN-1:0] mag;
        logic [W_IN-1:0]            rmag;
        logic [IDX_W-1:0]           ridx;
        logic                       vld;
    } state_t;

    state_t s_d, s_q;

    logic [N_MOD-1:0][W_IN-1:0] zs_now;
    logic [N_MOD-1:0][W_IN-1:0] mag_now;
    logic [W_IN-1:0]            peak_now;
    logic [IDX_W-1:0]           peak_idx_now;

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        localparam int BASE = m * NUM_PHASES * W_IN;
        logic signed [W_IN-1:0] zs_w;

        zseq_div3 #(.W_IN(W_IN)) u_zs (
            .ph_a (cur_in[BASE +: W_IN]),
            .ph_b (cur_in[BASE + W_IN +: W_IN]),
            .ph_c (cur_in[BASE + 2*W_IN +: W_IN]),
            .zs   (zs_w)
        );
        assign zs_now[m] = zs_w;

        ripple_abs #(.W_IN(W_IN)) u_rip (
            .zs_now  (zs_w),
            .zs_prev ($signed(s_q.prev[m])),
            .mag     (mag_now[m])
        );

        assign mag_out[m*W_IN +: W_IN] = s_q.mag[m];
    end

    peak_pick #(.N_MOD(N_MOD), .W_IN(W_IN), .IDX_W(IDX_W)) u_peak (
        .mags     (mag_now),
        .peak     (peak_now),
        .peak_idx (peak_idx_now)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (sample_stb) begin
            s_d.prev   = zs_now;
            s_d.primed = 1'b1;
            if (s_q.primed) begin
                s_d.mag  = mag_now;
                s_d.rmag = peak_now;
                s_d.ridx = peak_idx_now;
                s_d.vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ref_mag   = s_q.rmag;
    assign ref_idx   = s_q.ridx;
    assign out_valid = s_q.vld;
endmodule

// File: rtl/ccd_chk.sv
`timescale 1ns/1ps
module ccd_chk #(
    parameter int N_MOD = 4,
    parameter int W_IN  = 16,
    parameter int IDX_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sample_stb,
    input logic [N_MOD*W_IN-1:0]  mag_out,
    input logic [W_IN-1:0]        ref_mag,
    input logic [IDX_W-1:0]       ref_idx,
    input logic                   out_valid
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R3
    valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sample_stb));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(sample_stb)) |-> ($stable(ref_mag) && $stable(ref_idx) && $stable(mag_out)));

    // R7
    ref_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(ref_idx) < N_MOD));

    // R7
    ref_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(ref_idx) < N_MOD) |-> (mag_out[ref_idx*W_IN +: W_IN] == ref_mag));

    for (genvar m = 0; m < N_MOD; m++) begin : g_chk
        // R6
        ref_is_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (ref_mag >= mag_out[m*W_IN +: W_IN]));

        // R7
        tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && (m < int'(ref_idx))) |-> (mag_out[m*W_IN +: W_IN] < ref_mag));
    end
endmodule

bind circ_ripple_detect ccd_chk #(.N_MOD(N_MOD), .W_IN(W_IN), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .mag_out    (mag_out),
    .ref_mag    (ref_mag),
    .ref_idx    (ref_idx),
    .out_valid  (out_valid)
);

// File: tb/circ_ripple_detect_tb.sv
`timescale 1ns/1ps
module circ_ripple_detect_tb;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_stb = 1'b0;
    logic [N*3*W-1:0]  cur_in = '0;
    logic [N*W-1:0]    mag_out;
    logic [W-1:0]      ref_mag;
    logic [IW-1:0]     ref_idx;
    logic              out_valid;

    int n_chk = 0;
    int n_bad = 0;
    int ph [N][3];
    int prev_zs [N];
    int exp_mag [N];
    int exp_ref, exp_idx;
    bit primed = 0;
    bit done = 0;

    always #4 clk = ~clk;

    circ_ripple_detect #(.N_MOD(N), .W_IN(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .cur_in(cur_in),
        .mag_out(mag_out), .ref_mag(ref_mag), .ref_idx(ref_idx), .out_valid(out_valid)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mag_of(input int m);
        return int'(mag_out[m*W +: W]);
    endfunction

    // Drive one sample set and update the bench model.
    task automatic strobe(input bit first);
        int zs;
        @(negedge clk);
        for (int m = 0; m < N; m++)
            for (int p = 0; p < 3; p++)
                cur_in[(m*3+p)*W +: W] = W'(ph[m][p]);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        if (!first) begin
            exp_ref = -1; exp_idx = 0;
            for (int m = 0; m < N; m++) begin
                zs = (ph[m][0] + ph[m][1] + ph[m][2]) / 3;
                exp_mag[m] = (zs > prev_zs[m]) ? zs - prev_zs[m] : prev_zs[m] - zs;
                if (exp_mag[m] > exp_ref) begin exp_ref = exp_mag[m]; exp_idx = m; end
            end
        end
        for (int m = 0; m < N; m++) prev_zs[m] = (ph[m][0] + ph[m][1] + ph[m][2]) / 3;
    endtask

    task automatic check_all(input string tag);
        check({tag, " R3 valid"}, out_valid, 1);
        for (int m = 0; m < N; m++) check({tag, " R2 mag"}, mag_of(m), exp_mag[m]);
        check({tag, " R6 ref_mag"}, ref_mag, exp_ref);
        check({tag, " R7 ref_idx"}, ref_idx, exp_idx);
    endtask

    task automatic set_mod(input int m, input int a, input int b, input int c);
        ph[m][0] = a; ph[m][1] = b; ph[m][2] = c;
    endtask

    task automatic zero_all();
        for (int m = 0; m < N; m++) set_mod(m, 0, 0, 0);
    endtask

    task automatic t_reset();
        check("R5 valid", out_valid, 0);
        check("R5 ref_mag", ref_mag, 0);
        check("R5 ref_idx", ref_idx, 0);
        for (int m = 0; m < N; m++) check("R5 mag", mag_of(m), 0);
    endtask

    task automatic t_first();
        set_mod(0, 300, 0, 0); set_mod(1, -90, 0, 0); set_mod(2, 33, 0, 0); set_mod(3, 0, 0, 0);
        strobe(1);
        check("R4 valid", out_valid, 0);
        check("R4 ref_mag", ref_mag, 0);
        for (int m = 0; m < N; m++) check("R4 mag", mag_of(m), 0);
    endtask

    task automatic t_basic();
        set_mod(0, 100, 50, 0); set_mod(1, 30, 30, 30); set_mod(2, -300, 0, 0); set_mod(3, 12, 0, 0);
        strobe(0);
        check_all("basic");
    endtask

    task automatic t_hold();
        int r, i;
        r = ref_mag; i = ref_idx;
        repeat (3) @(negedge clk);
        check("R3 idle valid", out_valid, 0);
        check("R3 idle ref_mag", ref_mag, r);
        check("R3 idle ref_idx", ref_idx, i);
        for (int m = 0; m < N; m++) check("R3 idle mag", mag_of(m), exp_mag[m]);
    endtask

    task automatic t_round();
        zero_all(); strobe(0);
        set_mod(0, -5, 0, 0); set_mod(1, -4, 0, 0); set_mod(2, 8, 0, 0); set_mod(3, -2, -3, -3);
        strobe(0);
        check("R1 sum -5", mag_of(0), 1);
        check("R1 sum -4", mag_of(1), 1);
        check("R1 sum 8", mag_of(2), 2);
        check("R1 sum -8", mag_of(3), 2);
        check_all("R1 round");
    endtask

    task automatic t_alt();
        for (int k = 0; k < 4; k++) begin
            int s = (k % 2 == 0) ? 1 : -1;
            set_mod(0, s*600, s*600, s*600); set_mod(1, s*-150, 0, 0);
            set_mod(2, s*90, s*90, 0); set_mod(3, 7, 7, 7);
            strobe(0);
            check_all("R2 alternate");
        end
    endtask

    task automatic t_tie();
        zero_all(); strobe(0);
        set_mod(0, 30, 0, 0); set_mod(1, 900, 0, 0); set_mod(2, -30, 0, 0); set_mod(3, -900, 0, 0);
        strobe(0);
        check("R7 tie idx", ref_idx, 1);
        check("R7 tie mag", ref_mag, 300);
        check_all("R7 tie");
    endtask

    task automatic t_switch();
        zero_all(); strobe(0);
        set_mod(2, 3000, 0, 0); set_mod(0, 300, 0, 0);
        strobe(0);
        check("R8 ref to 2", ref_idx, 2);
        set_mod(2, 3000, 0, 0); set_mod(0, 6000, 0, 0);
        strobe(0);
        check("R8 ref to 0", ref_idx, 0);
        check_all("R8 switch");
    endtask

    task automatic t_full();
        for (int m = 0; m < N; m++) set_mod(m, 32767, 32767, 32767);
        strobe(0);
        for (int m = 0; m < N; m++) set_mod(m, -32768, -32768, -32768);
        strobe(0);
        check("R9 full mag", mag_of(0), 65535);
        check("R9 full ref", ref_mag, 65535);
        check_all("R9 full");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first();
        t_basic();
        t_hold();
        t_round();
        t_alt();
        t_tie();
        t_switch();
        t_full();
        t_hold();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule